// File: doc/BRIEF.md
# Legacy NMI Source Control Logic

This block owns two legacy I/O ports that govern the non-maskable interrupt. The system-control port, at I/O address 61h by default, latches two NMI causes. One is a board parity or system error input, which is active high. The other is an I/O channel check input, which is active low. Each cause has its own disable bit with inverted polarity: writing 1 turns the source off and wipes its latched status, and writing 0 turns it on. Software acknowledges a serviced cause by writing the disable bit to 1 and then back to 0. The same port also presents a synchronized copy of the speaker counter output and a refresh toggle as read-only bits. It holds the speaker data bit and the counter gate bit and drives both out to the timer and speaker logic.

The mask port, at 70h by default, holds the global NMI mask in bit 7. Its low seven bits are the RTC index, which this block stores and passes through unchanged on a dedicated output. The single NMI output is asserted while any cause is latched and the mask is clear.

The bus is a plain synchronous one: a write strobe with address and data is taken on the rising clock edge. Read data is combinational from the address.

Top module: `nmi_src_ctl`

## Requirements
- R1: After reset, the control port reads 0Ch, the mask port reads 80h, and `nmi_o`, `spk_data_o`, `tmr_gate_o` and `rtc_idx_o` are all 0.
- R2: The control port reads back its bits as follows:
  - bit 7: parity/system error status
  - bit 6: channel check status
  - bit 5: speaker counter (synchronized)
  - bit 4: refresh toggle
  - bit 3: channel check disable
  - bit 2: parity/system error disable
  - bit 1: speaker data
  - bit 0: counter gate

  A write to this port changes only bits 3:0.
- R3: While bit 2 is 0, a high level on `perr_in` (after the synchronizer) sets bit 7. Bit 7 stays set after the input returns low.
- R4: While bit 3 is 0, a low level on `chk_n_in` (after the synchronizer) sets bit 6. Bit 6 stays set after the input returns high.
- R5: Each disable bit works only on its own source (bit 2 on bit 7, bit 3 on bit 6):
  - Writing the bit to 1 clears that source's status on the edge that takes the write.
  - While the bit is 1, the source cannot set its status.
- R6: `nmi_o` is 1 exactly when bit 7 or bit 6 of the control port is set and the mask bit is 0. It follows a clear or a mask change on the same edge.
- R7: On the mask port, bit 7 is the NMI mask. Bits 6:0 are stored, read back unchanged and driven on `rtc_idx_o`.
- R8: Control-port bit 4 inverts on every clock cycle in which `refresh_tick` is 1. Control-port bit 5 follows `spk_cnt_in` after `SYNC_STAGES` clock edges.
- R9: `spk_data_o` and `tmr_gate_o` equal control-port bits 1 and 0.
- R10: Reads from any other address return 00h. Writes to any other address change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe, taken on the rising edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Combinational read data for `io_addr` |
| perr_in | input | 1 | Parity/system error request, active high, asynchronous |
| chk_n_in | input | 1 | I/O channel check request, active low, asynchronous |
| spk_cnt_in | input | 1 | Speaker counter output, asynchronous |
| refresh_tick | input | 1 | One-cycle refresh event in the `clk` domain |
| spk_data_o | output | 1 | Speaker data bit |
| tmr_gate_o | output | 1 | Speaker counter gate (1 enables) |
| rtc_idx_o | output | 7 | Stored RTC index bits |
| nmi_o | output | 1 | NMI request |

## Verification
The assertions assume that the bus never issues a write whose address matches both ports. They also assume that `refresh_tick` is already synchronous to `clk`. The bench meets both assumptions: it uses only fixed distinct addresses, and it drives every input, including the asynchronous ones, at the falling edge. Its sticky and clear properties assume that no write is in progress in the observed cycle. The bench therefore separates each write from the following read by at least one idle cycle. It also holds each source input for more than `SYNC_STAGES` + 1 cycles before it reads the status.

// File: rtl/nmi_src_pkg.sv
// Package: shared constants and types for the NMI source control block.
// Assumes an 8-bit I/O data bus; the bit order of the control port is
// software-visible and must not be changed.
package nmi_src_pkg;
    localparam int DATA_W    = 8;
    localparam int RTC_IDX_W = DATA_W - 1;
    localparam int NUM_SRC   = 2;
    localparam int SRC_PERR  = 0;
    localparam int SRC_CHK   = 1;

    // Writable low nibble of the control port, bit 3 down to bit 0.
    typedef struct packed {
        logic dis_chk;
        logic dis_perr;
        logic spk_data;
        logic tmr_gate;
    } ctl_t;

    localparam ctl_t CTL_RST = '{dis_chk: 1'b1, dis_perr: 1'b1,
                                 spk_data: 1'b0, tmr_gate: 1'b0};
endpackage

// File: rtl/nmi_sync.sv
// Module: multi-bit flip-flop chain that brings asynchronous levels into
// the clk domain. Assumes each bit is an independent slow level, so no
// cross-bit coherence is needed. Resets every stage to 0.
module nmi_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift the input through STAGES registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/nmi_src_latch.sv
// Module: sticky status flag for one NMI cause. Assumes src_active is
// already synchronous. dis_next is the disable bit value that the control
// register takes on this edge, so a disabling write clears the flag on
// the same edge that stores the write.
module nmi_src_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic src_active,
    input  logic dis_next,
    output logic status_q
);
    // Set on an active level while enabled; hold; clear while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= 1'b0;
        else        status_q <= !dis_next && (status_q || src_active);
    end
endmodule

// File: rtl/nmi_src_ctl.sv
// Module: legacy NMI source control. Decodes the control port and the
// mask port on a simple synchronous I/O bus, latches two NMI causes and
// merges them into nmi_o under the global mask. Assumes refresh_tick is
// synchronous to clk; perr_in, chk_n_in and spk_cnt_in may be asynchronous.
module nmi_src_ctl
    import nmi_src_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] CTL_PORT    = 'h61,
    parameter logic [ADDR_W-1:0] MSK_PORT    = 'h70,
    parameter int                SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic                 io_wr,
    input  logic [DATA_W-1:0]    io_wdata,
    output logic [DATA_W-1:0]    io_rdata,
    input  logic                 perr_in,
    input  logic                 chk_n_in,
    input  logic                 spk_cnt_in,
    input  logic                 refresh_tick,
    output logic                 spk_data_o,
    output logic                 tmr_gate_o,
    output logic [RTC_IDX_W-1:0] rtc_idx_o,
    output logic                 nmi_o
);
    localparam int SYNC_W = NUM_SRC + 1;

    ctl_t                 ctl_q, ctl_d;
    logic                 mask_q;
    logic [RTC_IDX_W-1:0] idx_q;
    logic                 refr_q;
    logic [SYNC_W-1:0]    sync_out;
    logic [NUM_SRC-1:0]   src_active;
    logic [NUM_SRC-1:0]   dis_next;
    logic [NUM_SRC-1:0]   st_q;
    logic                 spk_sync;
    logic                 wr_ctl, wr_msk;
    logic                 unused_wdata_hi;

    assign wr_ctl = io_wr && (io_addr == CTL_PORT);
    assign wr_msk = io_wr && (io_addr == MSK_PORT);
    assign unused_wdata_hi = ^io_wdata[DATA_W-1:4];

    // Next value of the writable control nibble.
    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctl) ctl_d = ctl_t'(io_wdata[3:0]);
    end

    // Control nibble register.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    // Mask bit and RTC index pass-through register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b1;
            idx_q  <= '0;
        end else if (wr_msk) begin
            mask_q <= io_wdata[DATA_W-1];
            idx_q  <= io_wdata[RTC_IDX_W-1:0];
        end
    end

    // Refresh indicator flips once per refresh event.
    always_ff @(posedge clk) begin
        if (!rst_n)            refr_q <= 1'b0;
        else if (refresh_tick) refr_q <= !refr_q;
    end

    nmi_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spk_cnt_in, !chk_n_in, perr_in}),
        .q     (sync_out)
    );

    assign spk_sync                = sync_out[NUM_SRC];
    assign src_active              = sync_out[NUM_SRC-1:0];
    assign dis_next[SRC_PERR]      = ctl_d.dis_perr;
    assign dis_next[SRC_CHK]       = ctl_d.dis_chk;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        nmi_src_latch u_latch (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_active (src_active[g]),
            .dis_next   (dis_next[g]),
            .status_q   (st_q[g])
        );
    end

    // Merge latched causes under the global mask.
    always_comb nmi_o = (|st_q) && !mask_q;

    // Read multiplexer for both ports.
    always_comb begin
        if (io_addr == CTL_PORT)
            io_rdata = {st_q[SRC_PERR], st_q[SRC_CHK], spk_sync, refr_q, ctl_q};
        else if (io_addr == MSK_PORT)
            io_rdata = {mask_q, idx_q};
        else
            io_rdata = '0;
    end

    assign spk_data_o = ctl_q.spk_data;
    assign tmr_gate_o = ctl_q.tmr_gate;
    assign rtc_idx_o  = idx_q;
endmodule

// File: rtl/nmi_src_chk.sv
// Module: assertion checker for nmi_src_ctl, bound to every instance.
// Assumes the two port addresses differ.
module nmi_src_chk #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CTL_PORT = 'h61,
    parameter logic [ADDR_W-1:0] MSK_PORT = 'h70
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              nmi_o,
    input logic [1:0]        st_q,
    input logic [1:0]        dis_q,
    input logic              mask_q
);
    AST_PERR_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == CTL_PORT && io_wdata[2]) |=> !st_q[0]); // R5
    AST_CHK_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == CTL_PORT && io_wdata[3]) |=> !st_q[1]); // R5
    AST_PERR_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_q[0] && !io_wr) |=> !st_q[0]); // R5
    AST_CHK_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_q[1] && !io_wr) |=> !st_q[1]); // R5
    AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q[0] && !dis_q[0] && !io_wr) |=> st_q[0]); // R3
    AST_CHK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q[1] && !dis_q[1] && !io_wr) |=> st_q[1]); // R4
    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |-> !nmi_o); // R6
    AST_STATUS_RAISES_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == CTL_PORT && io_rdata[7:6] != 2'b00 && !mask_q) |-> nmi_o); // R6
    AST_OTHER_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr != CTL_PORT && io_addr != MSK_PORT) |-> io_rdata == 8'h00); // R10
endmodule

bind nmi_src_ctl nmi_src_chk #(
    .ADDR_W   (ADDR_W),
    .CTL_PORT (CTL_PORT),
    .MSK_PORT (MSK_PORT)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .nmi_o    (nmi_o),
    .st_q     (st_q),
    .dis_q    ({ctl_q.dis_chk, ctl_q.dis_perr}),
    .mask_q   (mask_q)
);

// File: tb/test_nmi_src_ctl.sv
// Bench: scoreboard for nmi_src_ctl. The driver pushes expected read items;
// the monitor pops and compares them a quarter period after each falling edge.
module test_nmi_src_ctl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        perr_in = 1'b0;
    logic        chk_n_in = 1'b1;
    logic        spk_cnt_in = 1'b0;
    logic        refresh_tick = 1'b0;
    logic        spk_data_o, tmr_gate_o, nmi_o;
    logic [6:0]  rtc_idx_o;

    typedef struct {
        logic [15:0] addr;
        logic [7:0]  data;
        logic        nmi;
        logic [8:0]  side;
        string       tag;
    } item_t;
    item_t q[$];

    int n_chk = 0;
    int n_fail = 0;
    logic       e_perr = 0, e_chk = 0, e_mask = 1, e_spk = 0, e_gate = 0;
    logic [6:0] e_idx = '0;

    nmi_src_ctl i_nmi_src_ctl (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .perr_in(perr_in),
        .chk_n_in(chk_n_in), .spk_cnt_in(spk_cnt_in), .refresh_tick(refresh_tick),
        .spk_data_o(spk_data_o), .tmr_gate_o(tmr_gate_o), .rtc_idx_o(rtc_idx_o),
        .nmi_o(nmi_o)
    );

    always #(CLK_PERIOD/2) clk = !clk;

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_addr = '0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] d, input string tag);
        item_t it;
        @(negedge clk);
        io_addr = a; io_wr = 1'b0;
        it.addr = a; it.data = d; it.tag = tag;
        it.nmi  = (e_perr || e_chk) && !e_mask;
        it.side = {e_idx, e_spk, e_gate};
        q.push_back(it);
    endtask

    task automatic pulse_refresh();
        @(negedge clk); refresh_tick = 1'b1;
        @(negedge clk); refresh_tick = 1'b0;
    endtask

    // Monitor: compare queued expectations away from the rising edge.
    always begin
        item_t it;
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (q.size() > 0) begin
            it = q.pop_front();
            n_chk++;
            if (io_rdata !== it.data) begin
                n_fail++;
                $display("FAIL %s: rdata @%h got %h exp %h", it.tag, it.addr, io_rdata, it.data);
            end
            n_chk++;
            if (nmi_o !== it.nmi) begin
                n_fail++;
                $display("FAIL %s: nmi_o got %b exp %b", it.tag, nmi_o, it.nmi);
            end
            n_chk++;
            if ({rtc_idx_o, spk_data_o, tmr_gate_o} !== it.side) begin
                n_fail++;
                $display("FAIL %s: side outputs got %h exp %h", it.tag,
                         {rtc_idx_o, spk_data_o, tmr_gate_o}, it.side);
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run got no end, exp finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1: reset state
        rd(16'h61, 8'h0C, "R1");
        rd(16'h70, 8'h80, "R1");
        // R5: disabled parity source cannot latch
        perr_in = 1'b1; idle(4);
        rd(16'h61, 8'h0C, "R5");
        // R3: enable parity source, latch, sticky
        wr(16'h70, 8'h00); e_mask = 0;
        wr(16'h61, 8'h08); e_perr = 1;
        rd(16'h61, 8'h88, "R3");
        perr_in = 1'b0; idle(4);
        rd(16'h61, 8'h88, "R3");
        // R7 / R6: mask port
        wr(16'h70, 8'hAA); e_mask = 1; e_idx = 7'h2A;
        rd(16'h70, 8'hAA, "R7");
        rd(16'h61, 8'h88, "R6");
        wr(16'h70, 8'h15); e_mask = 0; e_idx = 7'h15;
        rd(16'h70, 8'h15, "R7");
        // R5: channel check held off while disabled
        chk_n_in = 1'b0; idle(4);
        rd(16'h61, 8'h88, "R5");
        // R4: enable channel check source, latch, sticky
        wr(16'h61, 8'h00); e_chk = 1;
        rd(16'h61, 8'hC0, "R4");
        chk_n_in = 1'b1; idle(4);
        rd(16'h61, 8'hC0, "R4");
        // R5: each disable bit clears only its own status
        wr(16'h61, 8'h04); e_perr = 0;
        rd(16'h61, 8'h44, "R5");
        wr(16'h61, 8'h00);
        rd(16'h61, 8'h40, "R5");
        wr(16'h61, 8'h08); e_chk = 0;
        rd(16'h61, 8'h08, "R6");
        // R2 / R9: upper write bits ignored, outputs follow bits 1:0
        wr(16'h61, 8'hF3); e_spk = 1; e_gate = 1;
        rd(16'h61, 8'h03, "R2");
        rd(16'h61, 8'h03, "R9");
        // R8: refresh toggle and speaker sync
        pulse_refresh();
        rd(16'h61, 8'h13, "R8");
        pulse_refresh();
        rd(16'h61, 8'h03, "R8");
        spk_cnt_in = 1'b1; idle(3);
        rd(16'h61, 8'h23, "R8");
        // R10: other addresses
        wr(16'h62, 8'hFF);
        rd(16'h61, 8'h23, "R10");
        rd(16'h62, 8'h00, "R10");
        wr(16'h71, 8'h80);
        rd(16'h70, 8'h15, "R10");
        rd(16'h60, 8'h00, "R10");
        // R3: parity source latches again once re-enabled
        perr_in = 1'b1; idle(4); e_perr = 1;
        rd(16'h61, 8'hA3, "R3");
        // R6: mask blocks a pending cause
        wr(16'h70, 8'h95); e_mask = 1;
        rd(16'h70, 8'h95, "R6");
        idle(3);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule